// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block is the slice of an interrupt controller that serves one processor. A distributor upstream presents, every cycle, the single most urgent pending interrupt it holds for this processor: an ID, the number of the processor that raised it (meaningful for software-generated interrupts) and an 8-bit priority, where a smaller number is more urgent. The block filters that candidate through a global enable and a priority threshold. It raises the processor interrupt line when the candidate passes and no interrupt is in service.

Software handles an interrupt by reading the acknowledge register. The read returns the candidate's ID and source, moves it to the in-service state and pulses a strobe so the distributor can drop it from pending. If nothing qualifies, the read returns the reserved ID 1023 and changes nothing. Software ends the interrupt by writing the acknowledged word back, unchanged, to the end-of-interrupt register. Only a matching word retires the interrupt, and it also pulses a strobe to the distributor. One interrupt may be in service at a time. While it is in service, no other interrupt is signalled or acknowledged.

The register port is a 32-bit word interface with separate read and write strobes. Read data is combinational in the cycle of the read, and side effects take place at the clock edge that ends it.

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset, signalling is disabled, the stored threshold is 0, nothing is in service, the running-priority register (offset 0x14) reads 0xFF and `cpu_irq` is low.
- R2: Bit 0 of the control register (offset 0x00) enables signalling. While it is 0, `cpu_irq` stays low and an acknowledge read returns 1023.
- R3: The threshold register (offset 0x04) stores only bits 7:4 of a write and reads back with bits 3:0 as zero. A candidate is forwarded only when its priority is numerically lower than the stored threshold.
- R4: `cpu_irq` is high in the same cycle in which a valid candidate is enabled, passes the threshold and nothing is in service. No clock edge lies between these inputs and the output.
- R5: An acknowledge read (offset 0x0C) of a qualifying candidate returns the ID in bits 9:0 and the source processor in bits 12:10. In that cycle it pulses `ack_stb` with `ack_id`. From the next cycle the interrupt is in service, the running priority equals its priority and `cpu_irq` is low.
- R6: An acknowledge read when nothing qualifies returns exactly 1023, gives no `ack_stb` and leaves the running priority unchanged.
- R7: While an interrupt is in service, `cpu_irq` stays low and acknowledge reads return 1023, even for a more urgent candidate.
- R8: Writing the acknowledged word (bits 12:0) to the end-of-interrupt register (offset 0x10) pulses `eoi_stb` with `eoi_id` in that cycle. From the next cycle, nothing is in service and the running priority is 0xFF.
- R9: An end-of-interrupt write whose ID or source differs from the in-service interrupt, or that arrives while nothing is in service, has no effect and gives no `eoi_stb`.
- R10: Reads of the running-priority register and of the highest-pending register (offset 0x18) have no side effects. The highest-pending register returns the candidate's source and ID word when a candidate is valid, and 1023 otherwise.
- R11: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 1 | Distributor presents a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_src | input | 3 | Requesting processor of the candidate |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| cpu_irq | output | 1 | Interrupt request to the processor |
| ack_stb | output | 1 | Candidate taken into service this cycle |
| ack_id | output | 10 | ID taken into service |
| eoi_stb | output | 1 | In-service interrupt retired this cycle |
| eoi_id | output | 10 | ID retired |

## Verification
The assertions watch invariants that must hold on every cycle. The line stays low while signalling is disabled or an interrupt is in service. It falls on the cycle after an acknowledge. The running priority reads idle whenever nothing is in service. A spurious acknowledge holds the running priority. A retire happens only from the in-service state, and a mismatching end-of-interrupt write leaves the service state in place. Only the directed scenarios can show the exact register words: the packing of the ID and source fields, the threshold's dropped low bits and the strict-less-than boundary. They also show that the highest-pending read has no side effect and that the line reasserts after a matching retire.

// File: rtl/irq_cif_pkg.sv
// Package: register offsets and derived constants shared by the
// per-CPU interrupt interface. Assumes byte offsets on an 8-bit address.
package irq_cif_pkg;

    localparam int CIF_ADDR_W = 8;

    localparam logic [CIF_ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [CIF_ADDR_W-1:0] OFS_PMASK = 8'h04;
    localparam logic [CIF_ADDR_W-1:0] OFS_ACK   = 8'h0C;
    localparam logic [CIF_ADDR_W-1:0] OFS_EOI   = 8'h10;
    localparam logic [CIF_ADDR_W-1:0] OFS_RUN   = 8'h14;
    localparam logic [CIF_ADDR_W-1:0] OFS_PEND  = 8'h18;

    // Decoded register-port operation for this cycle
    typedef struct packed {
        logic wr_ctrl;
        logic wr_pmask;
        logic wr_eoi;
        logic rd_ack;
    } cif_op_t;

endpackage

// File: rtl/irq_cif_regs.sv
// Module: configuration registers of the per-CPU interface.
// Holds the signalling enable and the implemented upper bits of the
// priority threshold. Assumes writes are decoded by the caller.
module irq_cif_regs #(
    parameter int PRIO_W    = 8,
    parameter int MASK_IMPL = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_pmask,
    input  logic [DATA_W-1:0] wdata,
    output logic              sig_en,
    output logic [PRIO_W-1:0] mask_val
);
    localparam int LOW_W = PRIO_W - MASK_IMPL;

    logic [MASK_IMPL-1:0] mask_hi;

    // Enable bit and threshold upper bits, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_en  <= 1'b0;
            mask_hi <= '0;
        end else begin
            if (wr_ctrl)
                sig_en <= wdata[0];
            if (wr_pmask)
                mask_hi <= wdata[PRIO_W-1:LOW_W];
        end
    end

    // Rebuild the full-width threshold with unimplemented bits as zero
    generate
        if (LOW_W > 0) begin : g_pad
            assign mask_val = {mask_hi, {LOW_W{1'b0}}};
        end else begin : g_full
            assign mask_val = mask_hi;
        end
    endgenerate

endmodule

// File: rtl/irq_cif_gate.sv
// Module: qualification of the distributor candidate.
// Purely combinational; a candidate qualifies when signalling is on,
// it is valid, beats the threshold strictly and nothing is in service.
module irq_cif_gate #(
    parameter int PRIO_W = 8
) (
    input  logic              sig_en,
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] mask_val,
    input  logic              busy,
    output logic              qualify
);
    logic beats_mask;

    // Strict numeric comparison against the threshold
    always_comb begin
        beats_mask = (cand_prio < mask_val);
        qualify    = sig_en && cand_valid && beats_mask && !busy;
    end

endmodule

// File: rtl/irq_cif_active.sv
// Module: in-service tracking for one active interrupt.
// Captures ID, source and priority on an accepted acknowledge and
// retires them only on an end-of-interrupt word that matches both.
module irq_cif_active #(
    parameter int ID_W   = 10,
    parameter int SRC_W  = 3,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [SRC_W-1:0]  cand_src,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              eoi_wr,
    input  logic [ID_W-1:0]   eoi_wid,
    input  logic [SRC_W-1:0]  eoi_wsrc,
    output logic              active,
    output logic [ID_W-1:0]   act_id,
    output logic [SRC_W-1:0]  act_src,
    output logic [PRIO_W-1:0] run_prio,
    output logic              retire
);
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    // A retire needs a live interrupt and an exact ID and source match
    always_comb begin
        retire = eoi_wr && active && (eoi_wid == act_id) && (eoi_wsrc == act_src);
    end

    // Service state: set on take, cleared on a matching retire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            act_id   <= '0;
            act_src  <= '0;
            run_prio <= IDLE_PRIO;
        end else if (retire) begin
            active   <= 1'b0;
            run_prio <= IDLE_PRIO;
        end else if (take) begin
            active   <= 1'b1;
            act_id   <= cand_id;
            act_src  <= cand_src;
            run_prio <= cand_prio;
        end
    end

endmodule

// File: rtl/irq_cpu_iface.sv
// Module: per-CPU interrupt acknowledge interface (top).
// Filters the distributor candidate, drives the processor line, and
// serves the control, threshold, acknowledge, end-of-interrupt,
// running-priority and highest-pending registers. Read data is
// combinational; side effects land on the closing clock edge.
module irq_cpu_iface #(
    parameter int ID_W      = 10,
    parameter int SRC_W     = 3,
    parameter int PRIO_W    = 8,
    parameter int MASK_IMPL = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = irq_cif_pkg::CIF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [SRC_W-1:0]  cand_src,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cpu_irq,
    output logic              ack_stb,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_stb,
    output logic [ID_W-1:0]   eoi_id
);
    import irq_cif_pkg::*;

    localparam int WORD_W = ID_W + SRC_W;
    localparam logic [ID_W-1:0] SPUR_ID = '1;

    cif_op_t           op;
    logic              sig_en;
    logic [PRIO_W-1:0] mask_val;
    logic              qualify;
    logic              active;
    logic [ID_W-1:0]   act_id;
    logic [SRC_W-1:0]  act_src;
    logic [PRIO_W-1:0] run_prio;
    logic              retire;
    logic [WORD_W-1:0] cand_word;
    logic [WORD_W-1:0] pend_word;

    // Decode the register-port strobes into operations
    always_comb begin
        op.wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
        op.wr_pmask = reg_wr && (reg_addr == ADDR_W'(OFS_PMASK));
        op.wr_eoi   = reg_wr && (reg_addr == ADDR_W'(OFS_EOI));
        op.rd_ack   = reg_rd && (reg_addr == ADDR_W'(OFS_ACK));
    end

    irq_cif_regs #(
        .PRIO_W    (PRIO_W),
        .MASK_IMPL (MASK_IMPL),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (op.wr_ctrl),
        .wr_pmask (op.wr_pmask),
        .wdata    (reg_wdata),
        .sig_en   (sig_en),
        .mask_val (mask_val)
    );

    irq_cif_gate #(
        .PRIO_W (PRIO_W)
    ) u_gate (
        .sig_en     (sig_en),
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .mask_val   (mask_val),
        .busy       (active),
        .qualify    (qualify)
    );

    irq_cif_active #(
        .ID_W   (ID_W),
        .SRC_W  (SRC_W),
        .PRIO_W (PRIO_W)
    ) u_active (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (ack_stb),
        .cand_id   (cand_id),
        .cand_src  (cand_src),
        .cand_prio (cand_prio),
        .eoi_wr    (op.wr_eoi),
        .eoi_wid   (reg_wdata[ID_W-1:0]),
        .eoi_wsrc  (reg_wdata[WORD_W-1:ID_W]),
        .active    (active),
        .act_id    (act_id),
        .act_src   (act_src),
        .run_prio  (run_prio),
        .retire    (retire)
    );

    // Processor line and distributor strobes
    always_comb begin
        cpu_irq = qualify;
        ack_stb = op.rd_ack && qualify;
        ack_id  = cand_id;
        eoi_stb = retire;
        eoi_id  = act_id;
    end

    // Words returned by acknowledge and highest-pending reads
    always_comb begin
        cand_word = qualify    ? {cand_src, cand_id} : {{SRC_W{1'b0}}, SPUR_ID};
        pend_word = cand_valid ? {cand_src, cand_id} : {{SRC_W{1'b0}}, SPUR_ID};
    end

    // Read multiplexer; unmapped offsets read zero
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                ADDR_W'(OFS_CTRL):  reg_rdata = DATA_W'(sig_en);
                ADDR_W'(OFS_PMASK): reg_rdata = DATA_W'(mask_val);
                ADDR_W'(OFS_ACK):   reg_rdata = DATA_W'(cand_word);
                ADDR_W'(OFS_RUN):   reg_rdata = DATA_W'(run_prio);
                ADDR_W'(OFS_PEND):  reg_rdata = DATA_W'(pend_word);
                default:            reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_cif_chk.sv
// Module: protocol checker for the per-CPU interface, bound to the top.
// Observes ports and internal service state; drives nothing.
module irq_cif_chk #(
    parameter int ID_W   = 10,
    parameter int SRC_W  = 3,
    parameter int PRIO_W = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              cpu_irq,
    input logic              ack_stb,
    input logic              eoi_stb,
    input logic              sig_en,
    input logic              active,
    input logic [ID_W-1:0]   act_id,
    input logic [SRC_W-1:0]  act_src,
    input logic [PRIO_W-1:0] run_prio
);
    import irq_cif_pkg::*;

    localparam int WORD_W = ID_W + SRC_W;

    logic ack_rd_c;
    logic eoi_wr_c;

    // Local decode of acknowledge reads and end-of-interrupt writes
    always_comb begin
        ack_rd_c = reg_rd && (reg_addr == ADDR_W'(OFS_ACK));
        eoi_wr_c = reg_wr && (reg_addr == ADDR_W'(OFS_EOI));
    end

    AST_IDLE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (run_prio == '1)); // R1

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_en |-> !cpu_irq); // R2

    AST_IRQ_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> (!cpu_irq && active)); // R5

    AST_SPURIOUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd_c && !cpu_irq && !eoi_stb) |=> $stable(run_prio)); // R6

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (!cpu_irq && !ack_stb)); // R7

    AST_RETIRE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_stb |-> (active ##1 !active)); // R8

    AST_MISMATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr_c && active && (reg_wdata[WORD_W-1:0] != {act_src, act_id}))
        |-> (!eoi_stb ##1 active)); // R9

endmodule

bind irq_cpu_iface irq_cif_chk #(
    .ID_W   (ID_W),
    .SRC_W  (SRC_W),
    .PRIO_W (PRIO_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cpu_irq   (cpu_irq),
    .ack_stb   (ack_stb),
    .eoi_stb   (eoi_stb),
    .sig_en    (sig_en),
    .active    (active),
    .act_id    (act_id),
    .act_src   (act_src),
    .run_prio  (run_prio)
);

// File: tb/irq_cpu_iface_bench.sv
// Directed bench for the per-CPU interrupt interface.
module irq_cpu_iface_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [2:0]  cand_src = '0;
    logic [7:0]  cand_prio = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq;
    logic        ack_stb;
    logic [9:0]  ack_id;
    logic        eoi_stb;
    logic [9:0]  eoi_id;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    irq_cpu_iface u_irq_cpu_iface (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_valid (cand_valid),
        .cand_id    (cand_id),
        .cand_src   (cand_src),
        .cand_prio  (cand_prio),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cpu_irq    (cpu_irq),
        .ack_stb    (ack_stb),
        .ack_id     (ack_id),
        .eoi_stb    (eoi_stb),
        .eoi_id     (eoi_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Read: drive at falling edge, sample mid-cycle, edge applies effects
    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic stb, output logic [9:0] id);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2;
        d = reg_rdata; stb = ack_stb; id = ack_id;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic stb, output logic [9:0] id);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        #2;
        stb = eoi_stb; id = eoi_id;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cand(input logic v, input logic [9:0] i, input logic [2:0] s, input logic [7:0] p);
        @(negedge clk);
        cand_valid = v; cand_id = i; cand_src = s; cand_prio = p;
        #2;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic s; logic [9:0] i;
        rd(8'h00, d, s, i); chk("R1 ctrl", d, 0);
        rd(8'h04, d, s, i); chk("R1 mask", d, 0);
        rd(8'h14, d, s, i); chk("R1 running", d, 32'hFF);
        chk("R1 irq", 32'(cpu_irq), 0);
    endtask

    task automatic t_disabled;
        logic [31:0] d; logic s; logic [9:0] i;
        wr(8'h04, 32'hF0, s, i);
        cand(1'b1, 10'd45, 3'd0, 8'h20);
        chk("R2 irq off", 32'(cpu_irq), 0);
        rd(8'h0C, d, s, i); chk("R2 ack spurious", d, 32'd1023);
        chk("R2 no ack strobe", 32'(s), 0);
    endtask

    task automatic t_mask;
        logic [31:0] d; logic s; logic [9:0] i;
        wr(8'h00, 32'h1, s, i);
        #2; chk("R4 irq high", 32'(cpu_irq), 1);
        wr(8'h04, 32'hFF, s, i);
        rd(8'h04, d, s, i); chk("R3 low bits dropped", d, 32'hF0);
        wr(8'h04, 32'h2F, s, i);
        #2; chk("R3 equal blocked", 32'(cpu_irq), 0);
        wr(8'h04, 32'h30, s, i);
        #2; chk("R3 lower passes", 32'(cpu_irq), 1);
    endtask

    task automatic t_side_free;
        logic [31:0] d; logic s; logic [9:0] i;
        rd(8'h18, d, s, i); chk("R10 pending word", d, 32'd45);
        chk("R10 no ack strobe", 32'(s), 0);
        rd(8'h14, d, s, i); chk("R10 running idle", d, 32'hFF);
        chk("R10 irq kept", 32'(cpu_irq), 1);
        rd(8'h40, d, s, i); chk("R11 unmapped", d, 0);
    endtask

    task automatic t_ack_eoi;
        logic [31:0] d; logic s; logic [9:0] i;
        cand(1'b1, 10'd3, 3'd5, 8'h10);
        rd(8'h0C, d, s, i); chk("R5 ack word", d, 32'h1403);
        chk("R5 ack strobe", 32'(s), 1); chk("R5 ack id", 32'(i), 3);
        chk("R5 irq low after", 32'(cpu_irq), 0);
        rd(8'h14, d, s, i); chk("R5 running", d, 32'h10);
        cand(1'b1, 10'd7, 3'd0, 8'h00);
        chk("R7 irq blocked", 32'(cpu_irq), 0);
        rd(8'h0C, d, s, i); chk("R7 ack spurious", d, 32'd1023);
        chk("R7 no strobe", 32'(s), 0);
        wr(8'h10, 32'h0003, s, i); chk("R9 src mismatch strobe", 32'(s), 0);
        wr(8'h10, 32'h1404, s, i); chk("R9 id mismatch strobe", 32'(s), 0);
        rd(8'h14, d, s, i); chk("R9 still active", d, 32'h10);
        wr(8'h10, 32'h1403, s, i); chk("R8 eoi strobe", 32'(s), 1);
        chk("R8 eoi id", 32'(i), 3);
        rd(8'h14, d, s, i); chk("R8 running idle", d, 32'hFF);
        chk("R8 irq back", 32'(cpu_irq), 1);
        wr(8'h10, 32'h1403, s, i); chk("R9 eoi when idle", 32'(s), 0);
    endtask

    task automatic t_spurious;
        logic [31:0] d; logic s; logic [9:0] i;
        cand(1'b0, 10'd9, 3'd1, 8'h00);
        chk("R6 irq none", 32'(cpu_irq), 0);
        rd(8'h0C, d, s, i); chk("R6 ack spurious", d, 32'd1023);
        chk("R6 no strobe", 32'(s), 0);
        rd(8'h14, d, s, i); chk("R6 running held", d, 32'hFF);
        rd(8'h18, d, s, i); chk("R10 pending none", d, 32'd1023);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset;
        t_disabled;
        t_mask;
        t_side_free;
        t_ack_eoi;
        t_spurious;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule